// File: doc/BRIEF.md
# Multi-Channel Compare PWM Timer

A free-running up counter, clocked through two cascaded clock dividers, feeds a set of compare channels. Each channel compares the running count against its own compare value and drives one PWM pin through a small output state machine. The counter length is chosen at run time. It counts to the all-ones value for that length and then wraps to zero, so the PWM period is fixed by the length and the total division.

In reset/set mode a channel output drops when the count reaches that channel's compare value. It rises when the count reaches the compare value of channel 0, not when the counter wraps. Channel 0 therefore sets the phase of the rising edge for every channel. Channel 0's own drop and rise fall on the same count. The rise is deferred by one counter clock, so its pin shows a low pulse one counter clock wide. Configuration arrives on parallel inputs and is used at every counter clock.

Each output unit is a three-state machine. `OU_LOW` drives the pin low. `OU_HIGH` drives it high. `OU_SETPEND` drives it low and holds a deferred rise. On a counter clock in static mode, the machine goes to `OU_HIGH` or `OU_LOW` according to the static bit. On a counter clock in reset/set mode, the transitions are:
- a reset and a set together go to `OU_SETPEND`;
- a reset alone goes to `OU_LOW`;
- a set alone goes to `OU_HIGH`;
- no event moves `OU_SETPEND` to `OU_HIGH`, and leaves `OU_LOW` and `OU_HIGH` where they are.

Synchronous reset puts every unit in `OU_LOW`.

Top module: `cmp_pwm_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count_o` becomes 0 and every `pwm_o` bit becomes 0.
- R2: `count_o` advances by one once every D1×D2 input clocks. D1 = 2^`div1_sel` (1, 2, 4, 8) and D2 = `div2_sel`+1 (1 to 8).
- R3: `len_sel` encodes the counter length: 0→8, 1→10, 2→12, 3→16 bits. The count runs to 2^L−1 and wraps to 0, so one period is 2^L×D1×D2 input clocks.
- R4: Each channel's 3-bit mode field (channel i at `mode_flat[3i+2:3i]`) selects reset/set with encoding 7. In that mode the pin goes low at the same clock edge at which `count_o` takes the channel's compare value (channel i at `ccr_flat[16i+15:16i]` by default).
- R5: In reset/set mode, a pin goes high at the edge at which `count_o` takes channel 0's compare value. The wrap to zero does not raise it.
- R6: When a channel's reset and set fall on the same count, the pin is low for exactly one counter clock and then high. This always applies to channel 0, and to any channel whose compare value equals channel 0's.
- R7: With channel 0's compare value at 0, the other reset/set pins rise together when the count wraps to 0. Each stays high until the count reaches its own compare value.
- R8: Mode encoding 0, and every encoding other than 7, drives the pin from that channel's bit of `static_bits`, updated at each counter clock.
- R9: A compare value above the current maximum count never matches. In reset/set mode that pin stays high once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| len_sel | input | 2 | Counter length select |
| div1_sel | input | SEL1_W (2) | First divider select, divide by 2^sel |
| div2_sel | input | SEL2_W (3) | Second divider select, divide by sel+1 |
| ccr_flat | input | NUM_CH×MAX_W (64) | Packed compare values, channel 0 lowest |
| mode_flat | input | NUM_CH×3 (12) | Packed output-mode fields, channel 0 lowest |
| static_bits | input | NUM_CH (4) | Static output level per channel |
| count_o | output | MAX_W (16) | Current counter value |
| pwm_o | output | NUM_CH (4) | PWM pins |

## Verification
The bench uses the default parameters: four channels and a 16-bit counter field. It varies the run-time selects to reach each behaviour within the cycle budget. An 8-bit length with divide-by-2 makes a full PWM period 512 clocks, so several complete waveforms can be compared count by count: a channel-0 phase, a wrap-aligned zero phase, a tie and an out-of-range compare. A 12-bit length at divide-by-1 shows the 4096-count wrap. The largest division, 64, is checked on step spacing only, because a full 12-bit period at that division would take 262144 clocks.

// File: rtl/cmp_pwm_pkg.sv
package cmp_pwm_pkg;

    localparam int LEN_SEL_W = 2;
    localparam int MODE_W    = 3;
    localparam logic [MODE_W-1:0] MODE_RESET_SET = 3'd7;

    typedef enum logic [1:0] {
        OU_LOW     = 2'd0,
        OU_HIGH    = 2'd1,
        OU_SETPEND = 2'd2
    } ou_state_t;

    function automatic int unsigned len_bits(input logic [LEN_SEL_W-1:0] sel);
        int unsigned b;
        unique case (sel)
            2'd0: b = 8;
            2'd1: b = 10;
            2'd2: b = 12;
            default: b = 16;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cmp_pwm_prescaler.sv
module cmp_pwm_prescaler #(
    parameter int SEL1_W = 2,
    parameter int SEL2_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL1_W-1:0] div1_sel,
    input  logic [SEL2_W-1:0] div2_sel,
    output logic              tick_o
);
    localparam int C1_W = (1 << SEL1_W) - 1;

    logic [C1_W-1:0]   c1_q;
    logic [SEL2_W-1:0] c2_q;
    logic [C1_W-1:0]   lim1;
    logic              stage1;
    logic              stage2;

    always_comb begin
        lim1   = ~({C1_W{1'b1}} << div1_sel);
        stage1 = (c1_q >= lim1);
        stage2 = (c2_q >= div2_sel);
        tick_o = stage1 && stage2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c1_q <= '0;
            c2_q <= '0;
        end else begin
            c1_q <= stage1 ? '0 : c1_q + 1'b1;
            if (stage1) begin
                c2_q <= stage2 ? '0 : c2_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmp_pwm_counter.sv
module cmp_pwm_counter
    import cmp_pwm_pkg::*;
#(
    parameter int MAX_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [LEN_SEL_W-1:0] len_sel,
    output logic [MAX_W-1:0]     cnt_o,
    output logic [MAX_W-1:0]     cnt_next_o
);
    logic [MAX_W-1:0] cnt_q;
    logic [MAX_W-1:0] max_v;
    int unsigned      lb;

    always_comb begin
        lb = len_bits(len_sel);
        if (lb > MAX_W) lb = MAX_W;
        max_v      = ~({MAX_W{1'b1}} << lb);
        cnt_next_o = (cnt_q >= max_v) ? '0 : cnt_q + 1'b1;
        cnt_o      = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_next_o;
        end
    end
endmodule

// File: rtl/cmp_pwm_outunit.sv
module cmp_pwm_outunit
    import cmp_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rs_mode,
    input  logic static_bit,
    input  logic rst_ev,
    input  logic set_ev,
    output logic pwm_o
);
    ou_state_t state_q;
    ou_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (tick) begin
            if (!rs_mode) begin
                state_d = static_bit ? OU_HIGH : OU_LOW;
            end else if (rst_ev && set_ev) begin
                state_d = OU_SETPEND;
            end else if (rst_ev) begin
                state_d = OU_LOW;
            end else if (set_ev) begin
                state_d = OU_HIGH;
            end else begin
                unique case (state_q)
                    OU_SETPEND: state_d = OU_HIGH;
                    OU_HIGH:    state_d = OU_HIGH;
                    OU_LOW:     state_d = OU_LOW;
                    default:    state_d = OU_LOW;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OU_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwm_o = (state_q == OU_HIGH);
    end
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
    import cmp_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int MAX_W  = 16,
    parameter int SEL1_W = 2,
    parameter int SEL2_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LEN_SEL_W-1:0]       len_sel,
    input  logic [SEL1_W-1:0]          div1_sel,
    input  logic [SEL2_W-1:0]          div2_sel,
    input  logic [NUM_CH*MAX_W-1:0]    ccr_flat,
    input  logic [NUM_CH*MODE_W-1:0]   mode_flat,
    input  logic [NUM_CH-1:0]          static_bits,
    output logic [MAX_W-1:0]           count_o,
    output logic [NUM_CH-1:0]          pwm_o
);
    logic             tick;
    logic [MAX_W-1:0] cnt_next;
    logic [NUM_CH-1:0] match;

    cmp_pwm_prescaler #(.SEL1_W(SEL1_W), .SEL2_W(SEL2_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .div1_sel (div1_sel),
        .div2_sel (div2_sel),
        .tick_o   (tick)
    );

    cmp_pwm_counter #(.MAX_W(MAX_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .len_sel    (len_sel),
        .cnt_o      (count_o),
        .cnt_next_o (cnt_next)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [MAX_W-1:0]  ccr_i;
        logic [MODE_W-1:0] mode_i;

        always_comb begin
            ccr_i    = ccr_flat[i*MAX_W +: MAX_W];
            mode_i   = mode_flat[i*MODE_W +: MODE_W];
            match[i] = tick && (cnt_next == ccr_i);
        end

        cmp_pwm_outunit u_out (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .rs_mode    (mode_i == MODE_RESET_SET),
            .static_bit (static_bits[i]),
            .rst_ev     (match[i]),
            .set_ev     (match[0]),
            .pwm_o      (pwm_o[i])
        );
    end
endmodule

// File: rtl/cmp_pwm_checker.sv
module cmp_pwm_checker
    import cmp_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int MAX_W  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     tick,
    input logic [LEN_SEL_W-1:0]     len_sel,
    input logic [NUM_CH*MODE_W-1:0] mode_flat,
    input logic [NUM_CH-1:0]        static_bits,
    input logic [NUM_CH-1:0]        match,
    input logic [MAX_W-1:0]         count_o,
    input logic [NUM_CH-1:0]        pwm_o
);
    logic [MAX_W-1:0] max_v;
    int unsigned      lb;

    always_comb begin
        lb = len_bits(len_sel);
        if (lb > MAX_W) lb = MAX_W;
        max_v = ~({MAX_W{1'b1}} << lb);
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$stable(count_o)) |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_o <= $past(max_v)));

    assert_out_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$stable(pwm_o)) |-> $past(tick));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic rs;
        always_comb rs = (mode_flat[i*MODE_W +: MODE_W] == MODE_RESET_SET);

        assert_reset_edge_R4: assert property (@(posedge clk) disable iff (rst)
            (tick && rs && match[i] && !match[0]) |=> !pwm_o[i]);

        assert_tie_low_R6: assert property (@(posedge clk) disable iff (rst)
            (tick && rs && match[i] && match[0]) |=> !pwm_o[i]);

        assert_static_R8: assert property (@(posedge clk) disable iff (rst)
            (tick && !rs) |=> (pwm_o[i] == $past(static_bits[i])));

        if (i > 0) begin : g_set
            assert_set_edge_R5: assert property (@(posedge clk) disable iff (rst)
                (tick && rs && match[0] && !match[i]) |=> pwm_o[i]);
        end
    end
endmodule

bind cmp_pwm_timer cmp_pwm_checker #(.NUM_CH(NUM_CH), .MAX_W(MAX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .len_sel     (len_sel),
    .mode_flat   (mode_flat),
    .static_bits (static_bits),
    .match       (match),
    .count_o     (count_o),
    .pwm_o       (pwm_o)
);

// File: tb/cmp_pwm_timer_tb.sv
module cmp_pwm_timer_tb;
    localparam int NUM_CH = 4;
    localparam int MAX_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [1:0]              len_sel = 2'd0;
    logic [1:0]              div1_sel = 2'd0;
    logic [2:0]              div2_sel = 3'd0;
    logic [MAX_W-1:0]        ccr [NUM_CH];
    logic [2:0]              mode [NUM_CH];
    logic [NUM_CH-1:0]       static_bits = '0;
    logic [NUM_CH*MAX_W-1:0] ccr_flat;
    logic [NUM_CH*3-1:0]     mode_flat;
    logic [MAX_W-1:0]        count_o;
    logic [NUM_CH-1:0]       pwm_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ccr_flat[i*MAX_W +: MAX_W] = ccr[i];
            mode_flat[i*3 +: 3]        = mode[i];
        end
    end

    cmp_pwm_timer #(.NUM_CH(NUM_CH), .MAX_W(MAX_W)) u_dut (
        .clk (clk), .rst (rst), .len_sel (len_sel), .div1_sel (div1_sel),
        .div2_sel (div2_sel), .ccr_flat (ccr_flat), .mode_flat (mode_flat),
        .static_bits (static_bits), .count_o (count_o), .pwm_o (pwm_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic restart(input logic [1:0] ls, input logic [1:0] d1, input logic [2:0] d2);
        @(negedge clk);
        rst = 1'b1; len_sel = ls; div1_sel = d1; div2_sel = d2;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        for (int i = 0; i < NUM_CH; i++) begin ccr[i] = '0; mode[i] = 3'd0; end
        static_bits = '1;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(count_o == 0, "R1 count in reset", count_o, 0);
        check(pwm_o == 0, "R1 pwm in reset", pwm_o, 0);
        static_bits = '0;
    endtask

    task automatic test_prescale(input logic [1:0] d1, input logic [2:0] d2);
        int d = (1 << d1) * (d2 + 1);
        logic [MAX_W-1:0] prev;
        restart(2'd3, d1, d2);
        prev = count_o;
        while (count_o == prev) @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            int n = 0;
            prev = count_o;
            while (count_o == prev && n < 1000) begin @(negedge clk); n++; end
            check(n == d && count_o == prev + 1, "R2 step spacing", n, d);
        end
    endtask

    task automatic test_wrap(input logic [1:0] ls, input int bits);
        int maxv = (1 << bits) - 1;
        int n = 0;
        restart(ls, 2'd0, 3'd0);
        while (count_o != maxv) @(negedge clk);
        @(negedge clk);
        check(count_o == 0, "R3 wrap to zero", count_o, 0);
        @(negedge clk); n = 1;
        while (count_o != 0) begin @(negedge clk); n++; end
        check(n == maxv + 1, "R3 period length", n, maxv + 1);
    endtask

    function automatic bit exp_out(input int v, input int c0, input int ci, input int maxv);
        if (ci > maxv) return 1'b1;
        if (ci == c0) return v != c0;
        return ((v - c0) & maxv) < ((ci - c0) & maxv);
    endfunction

    task automatic test_pwm(input int c0, input int c1, input int c2, input int c3, input string tag);
        int cv [NUM_CH];
        int bad [NUM_CH];
        int fa [NUM_CH];
        int fe [NUM_CH];
        int low0 = 0;
        int maxv = 255;
        int d = 2;
        bit zero_ok = 1'b1;
        cv[0] = c0; cv[1] = c1; cv[2] = c2; cv[3] = c3;
        for (int i = 0; i < NUM_CH; i++) begin
            ccr[i] = cv[i]; mode[i] = 3'd7; bad[i] = 0; fa[i] = 0; fe[i] = 0;
        end
        restart(2'd0, 2'd1, 3'd0);
        repeat (2 * 256 * d + 10) @(negedge clk);
        for (int t = 0; t < 256 * d; t++) begin
            @(negedge clk);
            for (int i = 0; i < NUM_CH; i++) begin
                bit e = exp_out(count_o, cv[0], cv[i], maxv);
                if (pwm_o[i] != e) begin
                    if (bad[i] == 0) begin fa[i] = pwm_o[i]; fe[i] = e; end
                    bad[i]++;
                end
            end
            if (!pwm_o[0]) low0++;
            if (count_o == 0 && c0 == 0 && pwm_o[3:1] != 3'b111) zero_ok = 1'b0;
        end
        for (int i = 0; i < NUM_CH; i++)
            check(bad[i] == 0, $sformatf("%s ch%0d waveform", tag, i), fa[i], fe[i]);
        check(low0 == d, "R6 ch0 pulse width", low0, d);
        if (c0 == 0) check(zero_ok, "R7 rise together at zero", 0, 1);
    endtask

    task automatic test_static();
        for (int i = 0; i < NUM_CH; i++) begin ccr[i] = 16'h0010; mode[i] = 3'd0; end
        mode[2] = 3'd5;
        static_bits = 4'b0110;
        restart(2'd0, 2'd0, 3'd0);
        repeat (3) @(negedge clk);
        check(pwm_o[1] == 1'b1, "R8 mode0 static high", pwm_o[1], 1);
        check(pwm_o[2] == 1'b1, "R8 unused encoding static", pwm_o[2], 1);
        check(pwm_o[0] == 1'b0, "R8 mode0 static low", pwm_o[0], 0);
        static_bits = 4'b0100;
        repeat (2) @(negedge clk);
        check(pwm_o[1] == 1'b0, "R8 static follows change", pwm_o[1], 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        test_reset();
        test_prescale(2'd1, 3'd2);
        test_prescale(2'd3, 3'd7);
        test_wrap(2'd0, 8);
        test_wrap(2'd2, 12);
        test_pwm(8'h30, 8'h60, 8'h10, 8'h30, "R4 R5 R6");
        test_pwm(0, 8'h40, 8'h80, 8'hC0, "R7");
        test_pwm(8'h20, 16'h01FF, 8'h80, 8'hF0, "R9");
        test_static();
        finish_run();
    end
endmodule